// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block decides whether a received I2C address byte is meant for this slave. Each byte that the shift logic marks valid has its upper seven bits compared with a programmed own address. When enabled, the byte is also compared with the general-call address. The lowest bit of the byte is reported as the transfer direction. On a hit, the unit tells the control logic with a single-cycle event pulse. It then holds the hit flags until the bus logic signals the end of the transaction. While addressed, it drives the acknowledge value that the control register's acknowledge-enable bit asks for.

The unit also serves a low-power mode. While the sleep input is high, a hit raises a one-cycle wake request alongside the event pulse. An unrelated wake event during sleep ends the transaction at once and returns the unit to idle.

The controller has three states. ST_IDLE waits for an address byte. ST_ADDRESSED holds a hit. ST_REJECTED swallows the rest of a transaction that was not for this slave. The transitions are:

- IDLE_TO_ADDRESSED: a valid byte hits.
- IDLE_TO_REJECTED: a valid byte misses.
- HOLD_TO_IDLE: transaction end arrives with no new byte.
- RESTART_EVAL: transaction end arrives in the same cycle as a new byte, so the new byte is evaluated as from idle.
- ABORT_TO_IDLE: an unrelated wake event arrives during sleep, from any state.

Top module: `slave_addr_match`

## Requirements
- R1: When `rx_byte[7:1]` equals `own_addr`, and R2 does not apply, `own_hit` is 1 after the clock edge that samples `rx_valid`, and `rw_bit` equals `rx_byte[0]` (1 = read).
- R2: With `gc_en`=1, the byte 0x00 (seven zero address bits, write) sets `gc_hit`=1 and `own_hit`=0, even when `own_addr` is zero.
- R3: The general call is not recognised when `gc_en`=0 or when the direction bit is 1. Byte 0x01 with `own_addr`=0 is an own-address read.
- R4: `match_pulse` is 1 for exactly the one cycle after the edge that samples a hitting byte; a missing byte gives no pulse.
- R5: `ack_out` (1 = drive ACK, 0 = release SDA for NACK) follows `ack_en` while addressed and is 0 in every other state.
- R6: When `sleep_mode`=1, `wake_pulse` rises together with `match_pulse`; it stays 0 on a miss and when not sleeping.
- R7: `wake_other`=1 with `sleep_mode`=1 returns the unit to idle, clears the hits and takes priority over a `rx_valid` in the same cycle. `wake_other` with `sleep_mode`=0 has no effect.
- R8: While addressed or rejected, further `rx_valid` strobes are ignored until `txn_end`. A `txn_end` together with `rx_valid` evaluates that byte as a new address.
- R9: After reset all outputs are 0 and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_byte | input | 8 | Received address byte, direction in bit 0 |
| rx_valid | input | 1 | Strobe: `rx_byte` holds an address byte |
| own_addr | input | 7 | Programmed own slave address |
| gc_en | input | 1 | General-call recognition enable |
| ack_en | input | 1 | Acknowledge enable from control register |
| txn_end | input | 1 | STOP or repeated START seen on the bus |
| sleep_mode | input | 1 | Unit is matching during sleep |
| wake_other | input | 1 | Unrelated wake event |
| own_hit | output | 1 | Own address matched |
| gc_hit | output | 1 | General call matched |
| rw_bit | output | 1 | Direction bit of the matched byte |
| ack_out | output | 1 | 1 = drive ACK, 0 = NACK |
| match_pulse | output | 1 | One-cycle match event |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is transaction end and a new address strobe. The bench holds an own-address hit, then raises `txn_end` and `rx_valid` together with a general-call byte. It expects `gc_hit`, a fresh `match_pulse` and a cleared `own_hit` after that edge.

The second pair is the sleep abort and an address strobe. With sleep active, the bench raises `wake_other` in the same cycle as a byte that would hit. It expects no hit, no event pulse and no wake pulse, because the abort takes priority.

// File: rtl/sam_pkg.sv
package sam_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BYTE_W = ADDR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ADDRESSED = 2'd1,
        ST_REJECTED  = 2'd2
    } sam_state_e;

    typedef struct packed {
        logic own_eq;
        logic gc_eq;
        logic rw;
    } cmp_res_t;
endpackage

// File: rtl/sam_cmp.sv
module sam_cmp
    import sam_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic [AW:0]   addr_byte,
    input  logic [AW-1:0] own_addr,
    input  logic          gc_en,
    output cmp_res_t      res
);
    localparam logic [AW-1:0] GC_ADDR = '0;

    logic [AW-1:0] bit_eq;
    logic [AW-1:0] bit_zero;

    // per-bit comparators against own address and general-call address
    for (genvar i = 0; i < AW; i++) begin : g_bits
        assign bit_eq[i]   = ~(addr_byte[i+1] ^ own_addr[i]);
        assign bit_zero[i] = ~(addr_byte[i+1] ^ GC_ADDR[i]);
    end

    logic gc_eq;
    assign gc_eq = gc_en && (&bit_zero) && !addr_byte[0];

    always_comb begin
        res.gc_eq  = gc_eq;
        res.own_eq = (&bit_eq) && !gc_eq;
        res.rw     = addr_byte[0];
    end
endmodule

// File: rtl/sam_fsm.sv
module sam_fsm
    import sam_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_valid,
    input  cmp_res_t cmp,
    input  logic     ack_en,
    input  logic     txn_end,
    input  logic     sleep_mode,
    input  logic     wake_other,
    output logic     own_hit,
    output logic     gc_hit,
    output logic     rw_bit,
    output logic     ack_out,
    output logic     match_pulse,
    output logic     wake_pulse
);
    sam_state_e state_q, state_d;
    logic own_q, gc_q, rw_q, pulse_q, wake_q;
    logic own_d, gc_d, rw_d, pulse_d, wake_d;
    logic abort, evaluate, hit;

    assign abort = sleep_mode && wake_other;
    assign hit   = cmp.own_eq || cmp.gc_eq;

    always_comb begin
        state_d  = state_q;
        own_d    = own_q;
        gc_d     = gc_q;
        rw_d     = rw_q;
        pulse_d  = 1'b0;
        wake_d   = 1'b0;
        evaluate = 1'b0;
        unique case (state_q)
            ST_IDLE: evaluate = rx_valid;
            ST_ADDRESSED,
            ST_REJECTED: begin
                if (txn_end) begin
                    // HOLD_TO_IDLE, or RESTART_EVAL when a byte comes with it
                    state_d  = ST_IDLE;
                    own_d    = 1'b0;
                    gc_d     = 1'b0;
                    rw_d     = 1'b0;
                    evaluate = rx_valid;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (evaluate) begin
            if (hit) begin
                state_d = ST_ADDRESSED;
                own_d   = cmp.own_eq;
                gc_d    = cmp.gc_eq;
                rw_d    = cmp.rw;
                pulse_d = 1'b1;
                wake_d  = sleep_mode;
            end else begin
                state_d = ST_REJECTED;
            end
        end
        if (abort) begin
            // ABORT_TO_IDLE overrides everything
            state_d = ST_IDLE;
            own_d   = 1'b0;
            gc_d    = 1'b0;
            rw_d    = 1'b0;
            pulse_d = 1'b0;
            wake_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            own_q   <= 1'b0;
            gc_q    <= 1'b0;
            rw_q    <= 1'b0;
            pulse_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            gc_q    <= gc_d;
            rw_q    <= rw_d;
            pulse_q <= pulse_d;
            wake_q  <= wake_d;
        end
    end

    always_comb begin
        own_hit     = own_q;
        gc_hit      = gc_q;
        rw_bit      = rw_q;
        match_pulse = pulse_q;
        wake_pulse  = wake_q;
        ack_out     = (state_q == ST_ADDRESSED) && ack_en;
    end
endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match
    import sam_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   rx_byte,
    input  logic          rx_valid,
    input  logic [AW-1:0] own_addr,
    input  logic          gc_en,
    input  logic          ack_en,
    input  logic          txn_end,
    input  logic          sleep_mode,
    input  logic          wake_other,
    output logic          own_hit,
    output logic          gc_hit,
    output logic          rw_bit,
    output logic          ack_out,
    output logic          match_pulse,
    output logic          wake_pulse
);
    cmp_res_t cmp;

    sam_cmp #(.AW(AW)) u_cmp (
        .addr_byte (rx_byte),
        .own_addr  (own_addr),
        .gc_en     (gc_en),
        .res       (cmp)
    );

    sam_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .cmp         (cmp),
        .ack_en      (ack_en),
        .txn_end     (txn_end),
        .sleep_mode  (sleep_mode),
        .wake_other  (wake_other),
        .own_hit     (own_hit),
        .gc_hit      (gc_hit),
        .rw_bit      (rw_bit),
        .ack_out     (ack_out),
        .match_pulse (match_pulse),
        .wake_pulse  (wake_pulse)
    );
endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
    parameter int unsigned AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW:0]   rx_byte,
    input logic          rx_valid,
    input logic [AW-1:0] own_addr,
    input logic          gc_en,
    input logic          ack_en,
    input logic          txn_end,
    input logic          sleep_mode,
    input logic          wake_other,
    input logic          own_hit,
    input logic          gc_hit,
    input logic          rw_bit,
    input logic          ack_out,
    input logic          match_pulse,
    input logic          wake_pulse
);
    p_hits_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_hit && gc_hit));
    p_gc_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit |-> !rw_bit);
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
    p_pulse_has_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (own_hit || gc_hit));
    p_ack_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |-> ((own_hit || gc_hit) && ack_en));
    p_wake_with_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> match_pulse);
    p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode && wake_other) |=> (!own_hit && !gc_hit && !match_pulse));
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_hit || gc_hit) && !txn_end && !(sleep_mode && wake_other))
        |=> ($stable(own_hit) && $stable(gc_hit) && $stable(rw_bit)));
endmodule

bind slave_addr_match sam_checker #(.AW(AW)) u_sam_checker (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en), .txn_end(txn_end),
    .sleep_mode(sleep_mode), .wake_other(wake_other), .own_hit(own_hit),
    .gc_hit(gc_hit), .rw_bit(rw_bit), .ack_out(ack_out),
    .match_pulse(match_pulse), .wake_pulse(wake_pulse)
);

// File: tb/slave_addr_match_tb.sv
module slave_addr_match_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic [6:0] own_addr = 7'h5A;
    logic       gc_en = 1'b0;
    logic       ack_en = 1'b1;
    logic       txn_end = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       wake_other = 1'b0;
    logic       own_hit, gc_hit, rw_bit, ack_out, match_pulse, wake_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    slave_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en), .txn_end(txn_end),
        .sleep_mode(sleep_mode), .wake_other(wake_other), .own_hit(own_hit),
        .gc_hit(gc_hit), .rw_bit(rw_bit), .ack_out(ack_out),
        .match_pulse(match_pulse), .wake_pulse(wake_pulse)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got own,gc,rw,ack,pulse,wake=%b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {own_hit, gc_hit, rw_bit, ack_out, match_pulse, wake_pulse};
    endfunction

    // one-cycle stimulus, sampled at the following falling edge
    task automatic drive(input logic [7:0] b, input logic v, input logic te, input logic wo);
        @(negedge clk);
        rx_byte = b; rx_valid = v; txn_end = te; wake_other = wo;
        @(negedge clk);
        rx_valid = 1'b0; txn_end = 1'b0; wake_other = 1'b0;
    endtask

    task automatic end_txn();
        drive(8'h00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R9 reset", outs(), 6'b000000);
    endtask

    task automatic t_own();
        own_addr = 7'h5A; ack_en = 1'b1; gc_en = 1'b0;
        drive(8'hB4, 1'b1, 1'b0, 1'b0);
        check("R1 own write hit", outs(), 6'b100110);
        @(negedge clk);
        check("R4 pulse drops", outs(), 6'b100100);
        ack_en = 1'b0; #1;
        check("R5 ack follows ack_en", outs(), 6'b100000);
        ack_en = 1'b1;
        end_txn();
        check("R8 txn_end to idle", outs(), 6'b000000);
        drive(8'hB5, 1'b1, 1'b0, 1'b0);
        check("R1 own read hit", outs(), 6'b101110);
        end_txn();
    endtask

    task automatic t_miss();
        drive(8'hB6, 1'b1, 1'b0, 1'b0);
        check("R4 R5 miss gives nack no pulse", outs(), 6'b000000);
        drive(8'hB4, 1'b1, 1'b0, 1'b0);
        check("R8 byte ignored while rejected", outs(), 6'b000000);
        end_txn();
    endtask

    task automatic t_gc();
        gc_en = 1'b1;
        drive(8'h00, 1'b1, 1'b0, 1'b0);
        check("R2 general call", outs(), 6'b010110);
        end_txn();
        gc_en = 1'b0;
        drive(8'h00, 1'b1, 1'b0, 1'b0);
        check("R3 gc disabled", outs(), 6'b000000);
        end_txn();
        gc_en = 1'b1;
        drive(8'h01, 1'b1, 1'b0, 1'b0);
        check("R3 gc read rejected", outs(), 6'b000000);
        end_txn();
        own_addr = 7'h00;
        drive(8'h00, 1'b1, 1'b0, 1'b0);
        check("R2 gc wins over own zero", outs(), 6'b010110);
        end_txn();
        drive(8'h01, 1'b1, 1'b0, 1'b0);
        check("R3 own zero read", outs(), 6'b101110);
        end_txn();
        own_addr = 7'h5A;
    endtask

    task automatic t_restart();
        drive(8'hB4, 1'b1, 1'b0, 1'b0);
        drive(8'h00, 1'b1, 1'b1, 1'b0);
        check("R8 restart with new byte", outs(), 6'b010110);
        end_txn();
    endtask

    task automatic t_sleep();
        sleep_mode = 1'b1;
        drive(8'hB5, 1'b1, 1'b0, 1'b0);
        check("R6 wake on hit", outs(), 6'b101111);
        drive(8'h00, 1'b0, 1'b0, 1'b1);
        check("R7 abort clears", outs(), 6'b000000);
        drive(8'hB6, 1'b1, 1'b0, 1'b0);
        check("R6 no wake on miss", outs(), 6'b000000);
        drive(8'h00, 1'b0, 1'b0, 1'b1);
        drive(8'hB4, 1'b1, 1'b0, 1'b1);
        check("R7 abort beats strobe", outs(), 6'b000000);
        drive(8'hB4, 1'b1, 1'b0, 1'b0);
        check("R7 idle after abort", outs(), 6'b100111);
        end_txn();
        sleep_mode = 1'b0;
        drive(8'hB4, 1'b1, 1'b0, 1'b0);
        check("R6 no wake when awake", outs(), 6'b100110);
        drive(8'h00, 1'b0, 1'b0, 1'b1);
        check("R7 wake_other ignored awake", outs(), 6'b100100);
        end_txn();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_own();
        t_miss();
        t_gc();
        t_restart();
        t_sleep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule